// File: doc/BRIEF.md
# Character Class Membership Matcher

This block decides, once per clock, whether an 8-bit character belongs to a character set loaded at run time. The set is held in a bank of comparators. Each comparator keeps a 32-bit control vector made of two 16-entry bit tables. The low nibble of the character selects a bit in the lower table, and the high nibble selects a bit in the upper table. That comparator reports a hit only when both selected bits are set.

One comparator can hold many characters at once. It stays exact as long as its members are closed under exchanging low nibbles with each other. A set that breaks this rule produces extra, unwanted hits, so it is split across several comparators. The comparator outputs are ORed together. The split itself is worked out off-line, and the vectors are written through a simple indexed write port.

A pattern-matching engine uses one such unit per character class. It feeds the unit a stream of characters with a valid strobe and reads back a one-bit registered hit.

Top module: `charclass_matcher`

## Requirements
- R1: Within a comparator's control vector, bits 0 to 15 form the low table. The value of character bits 3:0 picks one bit of this table (bit 0 of the character is the least significant selector).
- R2: Bits 16 to 31 form the high table. The value of character bits 7:4, plus 16, picks one bit of this table.
- R3: A comparator hits only when both picked bits are 1. If only the low table or only the high table is populated, nothing matches.
- R4: A set is loaded by setting, for every member, its low-table bit and its high-table bit. For example, the vector with bits 1, 2 and 22 set matches exactly 0x61 and 0x62.
- R5: A single comparator loaded with the bits for 0x61 and 0x52 also matches the nibble-exchanged characters 0x62 and 0x51, and matches nothing else.
- R6: The class output is the OR of all comparators. Loading 0x61 into one comparator and 0x52 into another matches exactly those two characters.
- R7: One comparator can hold a 240-member negated class. The vector 0xFFEF_FFFF matches every character except 0x40 to 0x4F.
- R8: A write with cfg_we high stores cfg_vec into comparator cfg_idx at the clock edge. A character presented in the same cycle as the write is judged against the old vector, and one presented in the next cycle is judged against the new one.
- R9: class_hit is registered. It shows the result for a character one clock edge after that character is presented with chr_valid high, and it is 0 after any edge where chr_valid was low.
- R10: Reset clears every control vector and class_hit. An all-zero vector matches no character and adds nothing to the OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control vector write strobe |
| cfg_idx | input | IDX_W (2) | Index of the comparator to write |
| cfg_vec | input | 32 | Control vector to store |
| chr_valid | input | 1 | Character strobe |
| chr_data | input | 8 | Character under test |
| class_hit | output | 1 | Registered class membership result |

## Verification
A character presented with chr_valid high at one rising edge produces its class_hit value after that edge. The bench therefore drives each character at a falling edge and samples the result at the next falling edge, one full edge later. A write takes effect at its own edge. To check the old-versus-new rule, the bench presents a character together with the write and then holds it for a second cycle, expecting the old result first and the new result second. Every configuration is swept over all 256 characters, and the expected value is computed arithmetically from the set being tested.

// File: rtl/ccm_pkg.sv
// Package: shared widths for the character class matcher.
// Assumes 8-bit characters split into two 4-bit nibbles.
package ccm_pkg;
    localparam int CHAR_W = 8;
    localparam int NIB_W  = CHAR_W / 2;
    localparam int TBL_N  = 1 << NIB_W;
    localparam int CTRL_W = 2 * TBL_N;
    typedef logic [CTRL_W-1:0] ctrl_vec_t;
    typedef logic [CHAR_W-1:0] char_t;
endpackage

// File: rtl/ccm_cfg_decode.sv
// Module: turns a write strobe plus index into one-hot per-comparator
// write enables. Assumes indices at or above NUM_CMP are dropped.
module ccm_cfg_decode #(
    parameter int NUM_CMP = 4,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    output logic [NUM_CMP-1:0] we_vec
);
    // One enable per comparator whose index equals idx.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_dec
        assign we_vec[g] = we && (int'(idx) == g);
    end
endmodule

// File: rtl/ccm_nibble_cmp.sv
// Module: one comparator. It holds a control vector made of a low table
// (bits 0..15) addressed by the low nibble and a high table (bits 16..31)
// addressed by the high nibble. Its hit output is combinational and is
// the AND of the two addressed bits.
// Assumes a synchronous active-low reset that clears the vector.
module ccm_nibble_cmp
    import ccm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  ctrl_vec_t wr_vec,
    input  char_t     chr,
    output ctrl_vec_t ctrl_q,
    output logic      hit
);
    logic [NIB_W-1:0] lo_nib;
    logic [NIB_W-1:0] hi_nib;

    // Store a new control vector on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_vec;
    end

    // Split the character and look up both tables.
    always_comb begin
        lo_nib = chr[NIB_W-1:0];
        hi_nib = chr[CHAR_W-1:NIB_W];
        hit    = ctrl_q[{1'b0, lo_nib}] & ctrl_q[{1'b1, hi_nib}];
    end
endmodule

// File: rtl/ccm_or_reduce.sv
// Module: ORs the hit lines of all comparators into one class hit.
// It builds a ripple chain through generate.
module ccm_or_reduce #(
    parameter int NUM_CMP = 4
) (
    input  logic [NUM_CMP-1:0] hits,
    output logic               any_hit
);
    logic [NUM_CMP:0] chain;

    assign chain[0] = 1'b0;
    // Each stage adds one comparator to the running OR.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_or
        assign chain[g+1] = chain[g] | hits[g];
    end
    assign any_hit = chain[NUM_CMP];
endmodule

// File: rtl/charclass_matcher.sv
// Module: top of the character class matcher. It holds a bank of NUM_CMP
// nibble comparators that all see the same character, ORs their hits and
// registers the result, qualified by chr_valid.
// Assumes the collision-free split of a set is computed off-line.
module charclass_matcher
    import ccm_pkg::*;
#(
    parameter int NUM_CMP = 4,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [CTRL_W-1:0]    cfg_vec,
    input  logic                 chr_valid,
    input  logic [CHAR_W-1:0]    chr_data,
    output logic                 class_hit
);
    logic [NUM_CMP-1:0]        wr_en;
    logic [NUM_CMP-1:0]        cmp_hit;
    logic [NUM_CMP*CTRL_W-1:0] ctrl_flat;
    logic                      any_hit;

    ccm_cfg_decode #(.NUM_CMP(NUM_CMP)) u_dec (
        .we     (cfg_we),
        .idx    (cfg_idx),
        .we_vec (wr_en)
    );

    // Bank of comparators, all fed with the same character.
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        ccm_nibble_cmp u_cmp (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en[g]),
            .wr_vec (cfg_vec),
            .chr    (chr_data),
            .ctrl_q (ctrl_flat[g*CTRL_W +: CTRL_W]),
            .hit    (cmp_hit[g])
        );
    end

    ccm_or_reduce #(.NUM_CMP(NUM_CMP)) u_or (
        .hits    (cmp_hit),
        .any_hit (any_hit)
    );

    // Register the class result, forced low when no character is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) class_hit <= 1'b0;
        else        class_hit <= chr_valid & any_hit;
    end
endmodule

// File: rtl/ccm_checker.sv
// Module: property checker for charclass_matcher, attached through bind.
// It watches the ports together with the per-comparator hits and stored vectors.
module ccm_checker
    import ccm_pkg::*;
#(
    parameter int NUM_CMP = 4,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [IDX_W-1:0]          cfg_idx,
    input logic [CTRL_W-1:0]         cfg_vec,
    input logic                      chr_valid,
    input logic                      class_hit,
    input logic [NUM_CMP-1:0]        cmp_hit,
    input logic [NUM_CMP*CTRL_W-1:0] ctrl_flat
);
    logic              last_we;
    logic [IDX_W-1:0]  last_idx;
    logic [CTRL_W-1:0] last_vec;
    logic              any_write;
    logic [CTRL_W-1:0] last_slot;

    // Remember the previous write and whether any write has happened.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_we   <= 1'b0;
            last_idx  <= '0;
            last_vec  <= '0;
            any_write <= 1'b0;
        end else begin
            last_we   <= cfg_we;
            last_idx  <= cfg_idx;
            last_vec  <= cfg_vec;
            any_write <= any_write | cfg_we;
        end
    end

    // Select the stored vector of the comparator written last.
    always_comb begin
        last_slot = '0;
        for (int i = 0; i < NUM_CMP; i++)
            if (int'(last_idx) == i) last_slot = ctrl_flat[i*CTRL_W +: CTRL_W];
    end

    AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        !chr_valid |=> !class_hit); // R9
    AST_HIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (chr_valid && (|cmp_hit)) |=> class_hit); // R6
    AST_HIT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        class_hit |-> ($past(chr_valid) && (|$past(cmp_hit)))); // R6
    AST_WRITE_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (last_we && (int'(last_idx) < NUM_CMP)) |-> (last_slot == last_vec)); // R8
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(ctrl_flat)); // R8
    AST_CLEAR_BANK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !any_write |-> (cmp_hit == '0)); // R10
endmodule

bind charclass_matcher ccm_checker #(.NUM_CMP(NUM_CMP)) u_ccm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_vec   (cfg_vec),
    .chr_valid (chr_valid),
    .class_hit (class_hit),
    .cmp_hit   (cmp_hit),
    .ctrl_flat (ctrl_flat)
);

// File: tb/test_charclass_matcher.sv
// Bench: sweeps all 256 characters against a series of vector
// configurations and computes the expected class hit arithmetically.
module test_charclass_matcher;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_CMP    = 4;
    localparam int IDX_W      = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [31:0]      cfg_vec = '0;
    logic             chr_valid = 1'b0;
    logic [7:0]       chr_data = '0;
    logic             class_hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    charclass_matcher #(.NUM_CMP(NUM_CMP)) i_charclass_matcher (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_vec(cfg_vec), .chr_valid(chr_valid), .chr_data(chr_data),
        .class_hit(class_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] c, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s char=0x%02h actual=%0b expected=%0b", req, c, act, exp);
        end
    endtask

    task automatic write_cfg(input int idx, input logic [31:0] vec);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_vec = vec;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NUM_CMP; i++) write_cfg(i, 32'h0);
    endtask

    // Present one character and sample class_hit one edge later.
    task automatic probe(input logic [7:0] c, input logic v, output logic got);
        @(negedge clk);
        chr_data = c; chr_valid = v;
        @(negedge clk);
        got = class_hit;
        chr_valid = 1'b0;
    endtask

    // Vector with one low-table bit and one high-table bit set.
    function automatic logic [31:0] pair_vec(input int lo, input int hi);
        logic [31:0] v = '0;
        v[lo] = 1'b1;
        v[16 + hi] = 1'b1;
        return v;
    endfunction

    initial begin
        logic got;
        logic exp;
        repeat (3) @(negedge clk);
        check("R10", 8'h00, class_hit, 1'b0);
        rst_n = 1'b1;

        // R10: bank after reset matches nothing
        for (int c = 0; c < 256; c++) begin
            probe(8'(c), 1'b1, got);
            check("R10", 8'(c), got, 1'b0);
        end

        // R1 R2 R3: one low line and one high line select exactly one character
        for (int k = 0; k < 4; k++) begin
            int lo = (k * 5 + 3) % 16;
            int hi = (k * 7 + 1) % 16;
            clear_all();
            write_cfg(k, pair_vec(lo, hi));
            for (int c = 0; c < 256; c++) begin
                probe(8'(c), 1'b1, got);
                exp = (c == hi * 16 + lo);
                check(k[0] ? "R2" : "R1", 8'(c), got, exp);
            end
        end

        // R3: only one table populated gives no match
        clear_all();
        write_cfg(0, 32'h0000_FFFF);
        write_cfg(1, 32'hFFFF_0000);
        for (int c = 0; c < 256; c++) begin
            probe(8'(c), 1'b1, got);
            check("R3", 8'(c), got, 1'b0);
        end

        // R4: bits 1, 2, 22 give {0x61, 0x62}
        clear_all();
        write_cfg(2, 32'h0040_0006);
        for (int c = 0; c < 256; c++) begin
            probe(8'(c), 1'b1, got);
            check("R4", 8'(c), got, (c == 'h61) || (c == 'h62));
        end

        // R5: {0x61, 0x52} in one comparator collides into 0x62 and 0x51
        clear_all();
        write_cfg(0, pair_vec(1, 6) | pair_vec(2, 5));
        for (int c = 0; c < 256; c++) begin
            probe(8'(c), 1'b1, got);
            exp = (c == 'h61) || (c == 'h52) || (c == 'h62) || (c == 'h51);
            check("R5", 8'(c), got, exp);
        end

        // R6: same set split across two comparators is exact
        clear_all();
        write_cfg(1, pair_vec(1, 6));
        write_cfg(3, pair_vec(2, 5));
        for (int c = 0; c < 256; c++) begin
            probe(8'(c), 1'b1, got);
            check("R6", 8'(c), got, (c == 'h61) || (c == 'h52));
        end

        // R7: negated class without 0x40..0x4F in one comparator
        clear_all();
        write_cfg(3, 32'hFFEF_FFFF);
        for (int c = 0; c < 256; c++) begin
            probe(8'(c), 1'b1, got);
            check("R7", 8'(c), got, (c / 16) != 4);
        end

        // R9: chr_valid low gives no hit even for a member
        probe(8'h10, 1'b0, got);
        check("R9", 8'h10, got, 1'b0);
        probe(8'h10, 1'b1, got);
        check("R9", 8'h10, got, 1'b1);

        // R10: zeroing the only populated comparator removes all hits
        write_cfg(3, 32'h0);
        for (int c = 0; c < 256; c++) begin
            probe(8'(c), 1'b1, got);
            check("R10", 8'(c), got, 1'b0);
        end

        // R8: character alongside the write sees old vector, next cycle new
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd0; cfg_vec = pair_vec(1, 6);
        chr_data = 8'h61; chr_valid = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R8", 8'h61, class_hit, 1'b0);
        @(negedge clk);
        check("R8", 8'h61, class_hit, 1'b1);
        chr_valid = 1'b0;
        @(negedge clk);
        check("R9", 8'h61, class_hit, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule